// File: doc/BRIEF.md
# Cascadable Right Shifter Slice

This block is a purely combinational right shifter for a 4-bit data slice. A control word selects a shift distance of zero to three places from its two lowest bits, and its upper bits are ignored. The shifted nibble leaves on the data output. The bits that fall off the low end leave on a carry-out nibble, so that slices can be chained into a wider shifter.

To shift a word wider than one slice, every slice gets the same control word. The carry-out of each slice feeds the carry-in of the next less significant slice. The carry-out holds the bits that were shifted off in its top positions. A receiving slice fills its vacated top positions from the same top positions of its carry-in. The most significant slice has its carry-in tied to zero, which gives a logical shift of the whole word. A shift of zero consumes no carry-in and produces an all-zero carry-out.

The slice width is a parameter. The shift distance always uses log2 of the width in control bits.

Top module: `shr_slice`

## Requirements
- R1: When control bits [1:0] are 00, the data output equals the data input.
- R2: When control bits [1:0] give k = 1, 2 or 3, data output bit i equals data input bit i+k for every i below 4-k.
- R3: For a shift k > 0, data output bits [3:4-k] equal carry-in bits [3:4-k]. Carry-in bits [3-k:0] have no effect on either output.
- R4: For a shift k > 0, carry-out bits [3:4-k] equal data input bits [k-1:0], and carry-out bits [3-k:0] are zero.
- R5: When control bits [1:0] are 00, the carry-out is 0000 and the carry-in has no effect on either output.
- R6: Control bits [3:2] have no effect on either output.
- R7: With the carry-in held at 0000, the data output is the data input logically shifted right by k, with zeros entering at the top.
- R8: Two slices that share one control word, with the upper slice's carry-out driving the lower slice's carry-in and the upper carry-in tied to zero, together shift the 8-bit word right by k. The lower slice's carry-out then holds the 8-bit word's low k bits in its top positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 4 | Data nibble to shift |
| cin_i | input | 4 | Bits shifted off the more significant neighbour, top-aligned |
| ctrl_i | input | 4 | Control word; bits [1:0] give the shift distance |
| data_o | output | 4 | Shifted data nibble |
| cout_o | output | 4 | Bits shifted off this slice, top-aligned, zero for a shift of 0 |

## Verification
The hardest case to reach is the cross-slice one. Carry bits must land in exactly the vacated positions, and carry-in bits outside the fill window must stay invisible. A single slice cannot show that a wide word shifts correctly. The bench therefore sweeps one slice through every combination of data, carry-in and control, including nonzero upper control bits and carry-in patterns that have stray bits below the fill window. It also drives a two-slice chain with walking, alternating and dense 8-bit words at every shift distance, and compares the joined result with an 8-bit shift.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int SHR_SLICE_W = 4;
  localparam int SHR_CTRL_W  = 4;

  function automatic int shr_amt_bits(input int width);
    return (width <= 1) ? 1 : $clog2(width);
  endfunction
endpackage

// File: rtl/shr_amt_dec.sv
module shr_amt_dec #(
  parameter int W  = shr_pkg::SHR_SLICE_W,
  parameter int CW = shr_pkg::SHR_CTRL_W,
  localparam int AW = shr_pkg::shr_amt_bits(W)
) (
  input  logic [CW-1:0] ctrl_i,
  output logic [W-1:0]  sel_o
);
  logic [AW-1:0] amt;

  assign amt = ctrl_i[AW-1:0];

  for (genvar k = 0; k < W; k++) begin : g_sel
    assign sel_o[k] = (amt == AW'(k));
  end

  if (CW > AW) begin : g_hi
    logic unused_ctrl_hi;
    assign unused_ctrl_hi = ^ctrl_i[CW-1:AW];
  end
endmodule

// File: rtl/shr_data_mux.sv
module shr_data_mux #(
  parameter int W = shr_pkg::SHR_SLICE_W
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] cin_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] data_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [W-1:0] cand;
    for (genvar k = 0; k < W; k++) begin : g_amt
      if (i + k < W) begin : g_own
        assign cand[k] = data_i[i+k];
      end else begin : g_fill
        assign cand[k] = cin_i[i];
      end
    end
    assign data_o[i] = |(cand & sel_i);
  end
endmodule

// File: rtl/shr_carry_mux.sv
module shr_carry_mux #(
  parameter int W = shr_pkg::SHR_SLICE_W
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] cout_o
);
  for (genvar j = 0; j < W; j++) begin : g_bit
    logic [W-1:0] cand;
    for (genvar k = 0; k < W; k++) begin : g_amt
      if (k > 0 && j + k >= W) begin : g_out
        assign cand[k] = data_i[j+k-W];
      end else begin : g_zero
        assign cand[k] = 1'b0;
      end
    end
    assign cout_o[j] = |(cand & sel_i);
  end
endmodule

// File: rtl/shr_slice.sv
module shr_slice #(
  parameter int W  = shr_pkg::SHR_SLICE_W,
  parameter int CW = shr_pkg::SHR_CTRL_W
) (
  input  logic [W-1:0]  data_i,
  input  logic [W-1:0]  cin_i,
  input  logic [CW-1:0] ctrl_i,
  output logic [W-1:0]  data_o,
  output logic [W-1:0]  cout_o
);
  logic [W-1:0] sel;

  shr_amt_dec #(.W(W), .CW(CW)) u_dec (
    .ctrl_i (ctrl_i),
    .sel_o  (sel)
  );

  shr_data_mux #(.W(W)) u_data (
    .data_i (data_i),
    .cin_i  (cin_i),
    .sel_i  (sel),
    .data_o (data_o)
  );

  shr_carry_mux #(.W(W)) u_carry (
    .data_i (data_i),
    .sel_i  (sel),
    .cout_o (cout_o)
  );
endmodule

// File: rtl/shr_slice_chk.sv
module shr_slice_chk #(
  parameter int W  = shr_pkg::SHR_SLICE_W,
  parameter int CW = shr_pkg::SHR_CTRL_W,
  localparam int AW = shr_pkg::shr_amt_bits(W)
) (
  input logic [W-1:0]  data_i,
  input logic [W-1:0]  cin_i,
  input logic [CW-1:0] ctrl_i,
  input logic [W-1:0]  data_o,
  input logic [W-1:0]  cout_o
);
  int           k;
  logic [W-1:0] ones;
  logic [W-1:0] lowm;

  always_comb begin
    ones = '1;
    k    = int'(ctrl_i[AW-1:0]);
    lowm = ones >> k;
    if (k == 0) begin
      p_pass_r1: assert (data_o == data_i);
      p_quiet_r5: assert (cout_o == '0);
    end else begin
      p_shift_r2: assert ((data_o & lowm) == (data_i >> k));
      p_fill_r3: assert ((data_o >> (W - k)) == (cin_i >> (W - k)));
      p_carry_top_r4: assert ((cout_o >> (W - k)) == (data_i & ~(ones << k)));
      p_carry_low_r4: assert ((cout_o & lowm) == '0);
    end
  end
endmodule

bind shr_slice shr_slice_chk #(.W(W), .CW(CW)) u_chk (
  .data_i (data_i),
  .cin_i  (cin_i),
  .ctrl_i (ctrl_i),
  .data_o (data_o),
  .cout_o (cout_o)
);

// File: tb/sim_shr_slice.sv
module sim_shr_slice;
  logic clk;
  logic rst_n;
  int   checks;
  int   errors;
  int   cycles;
  bit   done;

  logic [3:0] d0, c0, k0, q0, co0;
  logic [3:0] dh, dl, kc, qh, ql, ch, cl;

  shr_slice u0 (.data_i(d0), .cin_i(c0), .ctrl_i(k0), .data_o(q0), .cout_o(co0));
  shr_slice u1 (.data_i(dh), .cin_i(4'h0), .ctrl_i(kc), .data_o(qh), .cout_o(ch));
  shr_slice u2 (.data_i(dl), .cin_i(ch), .ctrl_i(kc), .data_o(ql), .cout_o(cl));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (d=%0h cin=%0h ctrl=%0h)",
               req, act, exp, d0, c0, k0);
    end
  endtask

  function automatic int ref_out(int d, int cin, int sh);
    int keep = 15 >> sh;
    return ((d >> sh) | (cin & ~keep)) & 15;
  endfunction

  function automatic int ref_cout(int d, int sh);
    if (sh == 0) return 0;
    return (d << (4 - sh)) & 15;
  endfunction

  task automatic run_chain(input int w, input int sh, input int hi);
    int wide;
    @(posedge clk);
    #1;
    dh = 4'(w >> 4);
    dl = 4'(w);
    kc = 4'((hi << 2) | sh);
    wide = (w << 8) >> sh;
    @(negedge clk);
    checks++;
    if ({qh, ql} != 8'(wide >> 8)) begin
      errors++;
      $display("FAIL R8 word actual=%0h expected=%0h", {qh, ql}, 8'(wide >> 8));
    end
    check("R8 carry", int'(cl), (wide & 255) >> 4);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; cycles = 0; done = 0;
    rst_n = 1'b0;
    d0 = '0; c0 = '0; k0 = '0; dh = '0; dl = '0; kc = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset out", int'(q0), 0);
    check("R5 reset cout", int'(co0), 0);

    for (int ctl = 0; ctl < 16; ctl++) begin
      for (int cin = 0; cin < 16; cin++) begin
        for (int d = 0; d < 16; d++) begin
          int sh;
          sh = ctl & 3;
          @(posedge clk);
          #1;
          d0 = 4'(d); c0 = 4'(cin); k0 = 4'(ctl);
          @(negedge clk);
          if (sh == 0) begin
            check("R1 pass", int'(q0), d);
            check("R5 cout zero", int'(co0), 0);
          end else begin
            check("R2 shift", int'(q0) & (15 >> sh), d >> sh);
            check("R3 fill", int'(q0) >> (4 - sh), cin >> (4 - sh));
            check("R4 carry", int'(co0), ref_cout(d, sh));
          end
          if (cin == 0) check("R7 logical", int'(q0), d >> sh);
          if (ctl >= 4) check("R6 upper ctrl", int'(q0), ref_out(d, cin, sh));
          else          check("R3 R5 full", int'(q0), ref_out(d, cin, sh));
        end
      end
    end

    for (int sh = 0; sh < 4; sh++) begin
      run_chain(8'h80, sh, 0);
      run_chain(8'h01, sh, 3);
      run_chain(8'hA5, sh, 1);
      run_chain(8'h5A, sh, 2);
      run_chain(8'hFF, sh, 0);
      run_chain(8'h18, sh, 0);
      for (int b = 0; b < 8; b++) run_chain(1 << b, sh, b & 3);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule